// File: doc/BRIEF.md
# Byte-Serial Dot-Product Frame Sequencer

This block sits between a pair of narrow byte ports and a multiply-accumulate core. It loops over a fixed frame slot with no gaps. At the start of the slot it collects twenty bytes from the input port and packs them into five 32-bit words: two multiplicand words, two multiplier words and a seed word. It then spends three cycles driving the core: a seed load, followed by one multiply-add strobe for each operand pair. In the last four cycles it sends the 32-bit result back out of the output byte port.

The arithmetic is not part of this block. It is done by an external core, which sees a clock enable, a seed strobe, a step strobe and two operand words. The core returns its accumulator value on `core_result`, updated on each enabled edge. The final result is copied into entry 0 of a small two-entry result store. This is a fixed, counter-timed slot rather than a valid/ready stream. There is no back-pressure: the sender must present byte k of a frame in slot cycle k, and the receiver must take the output bytes in the cycles where they appear. The bidirectional pins are never driven.

Top module: `byte_frame_seq`

## Requirements
- R1: A frame is exactly 27 cycles long, numbered 0 to 26. Cycles 0–19 load, cycles 20–22 run the core and cycles 23–26 emit. After cycle 26 the next frame begins at cycle 0 with no idle cycle.
- R2: While `rst_n` is low, the outputs show cycle 0 (`out_byte` is zero and `core_en` is low). The first cycle after release is cycle 0 of a new frame, even if reset arrived in the middle of a frame.
- R3: The byte taken in cycle k goes into operand group k/4 at bits [8*(k%4)+7 : 8*(k%4)], so the first byte of a group is the least significant. The groups, in order, are a0, a1, b0, b1 and the seed c0.
- R4: Cycle 20 raises `core_seed` with `core_x` = c0 and `core_y` = 0. Cycle 21 raises `core_step` with a0 and b0. Cycle 22 raises `core_step` with a1 and b1.
- R5: `core_en` is high only in cycles 20–22. In each of those cycles exactly one of `core_seed` and `core_step` is high. Outside them both strobes are low and `core_x` and `core_y` are zero.
- R6: In cycle 23 the accumulator value is written to entry 0 of the result store, with a one-cycle write latency. Cycles 23–26 emit that value on `out_byte` least significant byte first. Byte 0 is forwarded from `core_result` because the store write has not landed yet.
- R7: `out_byte` is zero in every cycle outside 23–26.
- R8: `uio_out` and `uio_oe` are always zero.
- R9: Bytes on `in_byte` during cycles 20–26 are ignored and do not change the operands or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_byte | input | 8 | Serial operand byte for the current slot cycle |
| out_byte | output | 8 | Result byte during emit cycles, zero otherwise |
| uio_out | output | 8 | Bidirectional pin outputs, tied low |
| uio_oe | output | 8 | Bidirectional pin output enables, tied low |
| core_en | output | 1 | Clock enable for the accumulator core |
| core_seed | output | 1 | Load accumulator from `core_x` |
| core_step | output | 1 | Add `core_x * core_y` to the accumulator |
| core_x | output | 32 | First operand word to the core |
| core_y | output | 32 | Second operand word to the core |
| core_result | input | 32 | Accumulator value returned by the core |

## Verification
The hardest condition to reach is the forwarding of byte 0. It only shows up when the value in the store from the previous frame differs from the new result. For that reason the stimulus runs many random frames back to back without a reset in between, and the results change from one frame to the next. A reset in the middle of a frame checks that a partly loaded frame cannot leak into the next one. Random bytes on `in_byte` during the run and emit cycles check that those bytes are ignored.

// File: rtl/byte_frame_pkg.sv
package byte_frame_pkg;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = 32;
  localparam int BPW       = WORD_W / BYTE_W;
  localparam int N_TERMS   = 2;
  localparam int N_WORDS   = 2 * N_TERMS + 1;
  localparam int SEED_IDX  = 2 * N_TERMS;
  localparam int LOAD_CYC  = N_WORDS * BPW;
  localparam int RUN_CYC   = N_TERMS + 1;
  localparam int EMIT_CYC  = BPW;
  localparam int FRAME_CYC = LOAD_CYC + RUN_CYC + EMIT_CYC;
  localparam int RUN0      = LOAD_CYC;
  localparam int EMIT0     = LOAD_CYC + RUN_CYC;
  localparam int CNT_W     = $clog2(FRAME_CYC);

  typedef enum logic [1:0] {
    PH_LOAD = 2'd0,
    PH_RUN  = 2'd1,
    PH_EMIT = 2'd2
  } phase_t;
endpackage

// File: rtl/frame_counter.sv
module frame_counter
  import byte_frame_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output phase_t           phase
);
  always_ff @(posedge clk) begin
    if (!rst_n)                                 cnt <= '0;
    else if (cnt == CNT_W'(FRAME_CYC - 1))      cnt <= '0;
    else                                        cnt <= cnt + 1'b1;
  end

  always_comb begin
    if (cnt < CNT_W'(RUN0))       phase = PH_LOAD;
    else if (cnt < CNT_W'(EMIT0)) phase = PH_RUN;
    else                          phase = PH_EMIT;
  end
endmodule

// File: rtl/operand_loader.sv
module operand_loader
  import byte_frame_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            load_en,
  input  logic [CNT_W-1:0]                slot,
  input  logic [BYTE_W-1:0]               in_byte,
  output logic [N_WORDS-1:0][WORD_W-1:0]  words
);
  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    for (genvar l = 0; l < BPW; l++) begin : g_lane
      always_ff @(posedge clk) begin
        if (!rst_n)
          words[w][BYTE_W*l +: BYTE_W] <= '0;
        else if (load_en && slot == CNT_W'(w * BPW + l))
          words[w][BYTE_W*l +: BYTE_W] <= in_byte;
      end
    end
  end
endmodule

// File: rtl/result_store.sv
module result_store #(
  parameter int DEPTH = 2,
  parameter int W     = 32,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                                mem[i] <= '0;
      else if (wr_en && wr_idx == IW'(i))        mem[i] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/byte_frame_seq.sv
module byte_frame_seq
  import byte_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        in_byte,
  output logic [7:0]        out_byte,
  output logic [7:0]        uio_out,
  output logic [7:0]        uio_oe,
  output logic              core_en,
  output logic              core_seed,
  output logic              core_step,
  output logic [31:0]       core_x,
  output logic [31:0]       core_y,
  input  logic [31:0]       core_result
);
  logic [CNT_W-1:0]               cnt;
  phase_t                         phase;
  logic [N_WORDS-1:0][WORD_W-1:0] words;
  logic                           store_we;
  logic [WORD_W-1:0]              store_q;

  frame_counter u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (cnt),
    .phase (phase)
  );

  operand_loader u_ld (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (phase == PH_LOAD),
    .slot    (cnt),
    .in_byte (in_byte),
    .words   (words)
  );

  // Core drive: seed first, then one step per operand pair
  always_comb begin
    core_en   = (phase == PH_RUN);
    core_seed = 1'b0;
    core_step = 1'b0;
    core_x    = '0;
    core_y    = '0;
    if (cnt == CNT_W'(RUN0)) begin
      core_seed = 1'b1;
      core_x    = words[SEED_IDX];
    end
    for (int k = 0; k < N_TERMS; k++) begin
      if (cnt == CNT_W'(RUN0 + 1 + k)) begin
        core_step = 1'b1;
        core_x    = words[k];
        core_y    = words[N_TERMS + k];
      end
    end
  end

  assign store_we = (cnt == CNT_W'(EMIT0));

  result_store #(.DEPTH(2), .W(WORD_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (store_we),
    .wr_idx  (1'b0),
    .wr_data (core_result),
    .rd_idx  (1'b0),
    .rd_data (store_q)
  );

  // Emit mux: byte 0 forwarded while the store write is in flight
  always_comb begin
    out_byte = '0;
    if (cnt == CNT_W'(EMIT0)) out_byte = core_result[BYTE_W-1:0];
    for (int k = 1; k < EMIT_CYC; k++) begin
      if (cnt == CNT_W'(EMIT0 + k)) out_byte = store_q[BYTE_W*k +: BYTE_W];
    end
  end

  assign uio_out = '0;
  assign uio_oe  = '0;
endmodule

// File: rtl/byte_frame_seq_chk.sv
module byte_frame_seq_chk
  import byte_frame_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic             core_en,
  input logic             core_seed,
  input logic             core_step,
  input logic [31:0]      core_x,
  input logic [31:0]      core_y,
  input logic             store_we,
  input logic [7:0]       out_byte,
  input logic [7:0]       uio_out,
  input logic [7:0]       uio_oe
);
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(FRAME_CYC)); // R1
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == CNT_W'(FRAME_CYC - 1) |=> cnt == '0); // R1
  AST_SEED_THEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    core_seed |=> core_step && !core_seed); // R4
  AST_RUN_END: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == CNT_W'(EMIT0 - 1) |=> !core_en); // R5
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |-> $onehot({core_seed, core_step})); // R5
  AST_IDLE_OPS: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |-> (core_x == '0 && core_y == '0 && !core_seed && !core_step)); // R5
  AST_STORE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    store_we |-> $past(core_step) && !core_en); // R6
  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(EMIT0) |-> out_byte == '0); // R7
  AST_UIO_LOW: assert property (@(posedge clk)
    uio_out == '0 && uio_oe == '0); // R8
endmodule

bind byte_frame_seq byte_frame_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt       (cnt),
  .core_en   (core_en),
  .core_seed (core_seed),
  .core_step (core_step),
  .core_x    (core_x),
  .core_y    (core_y),
  .store_we  (store_we),
  .out_byte  (out_byte),
  .uio_out   (uio_out),
  .uio_oe    (uio_oe)
);

// File: tb/byte_frame_seq_tb.sv
module byte_frame_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  in_byte = '0;
  logic [7:0]  out_byte, uio_out, uio_oe;
  logic        core_en, core_seed, core_step;
  logic [31:0] core_x, core_y, core_result;
  logic [31:0] acc;
  int checks = 0;
  int errors = 0;
  logic [7:0] fb [20];

  always #5 clk = ~clk;

  byte_frame_seq u_dut (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .out_byte(out_byte),
    .uio_out(uio_out), .uio_oe(uio_oe), .core_en(core_en),
    .core_seed(core_seed), .core_step(core_step), .core_x(core_x),
    .core_y(core_y), .core_result(core_result)
  );

  // Stand-in accumulator core (integer multiply-add)
  always @(posedge clk) begin
    if (!rst_n) acc <= '0;
    else if (core_en) acc <= core_seed ? core_x : acc + core_x * core_y;
  end
  assign core_result = acc;

  function automatic logic [31:0] word_of(int g);
    return {fb[4*g+3], fb[4*g+2], fb[4*g+1], fb[4*g]};
  endfunction

  function automatic logic [31:0] expect_result();
    return word_of(4) + word_of(0) * word_of(2) + word_of(1) * word_of(3);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Called just after a negedge where the slot is at cycle 0
  task automatic run_frame();
    logic [31:0] r;
    r = expect_result();
    for (int c = 0; c < 27; c++) begin
      in_byte = (c < 20) ? fb[c] : 8'($urandom); // R9 junk outside load
      #1;
      chk("R8", {uio_out, uio_oe}, 16'h0);
      if (c < 20 || c > 22) begin
        chk("R5", {core_en, core_seed, core_step}, 3'b000);
        chk("R5", {core_x, core_y}, 64'h0);
      end
      if (c == 20) begin
        chk("R4", {core_en, core_seed, core_step}, 3'b110);
        chk("R3", {core_x, core_y}, {word_of(4), 32'h0});
      end
      if (c == 21) begin
        chk("R4", {core_en, core_seed, core_step}, 3'b101);
        chk("R3", {core_x, core_y}, {word_of(0), word_of(2)});
      end
      if (c == 22) begin
        chk("R4", {core_en, core_seed, core_step}, 3'b101);
        chk("R3", {core_x, core_y}, {word_of(1), word_of(3)});
      end
      if (c >= 23) chk("R6", {56'h0, out_byte}, {56'h0, r[8*(c-23) +: 8]});
      else         chk("R7", {56'h0, out_byte}, 64'h0);
      @(negedge clk);
    end
  endtask

  task automatic fill_random();
    for (int i = 0; i < 20; i++) fb[i] = 8'($urandom);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    #1;
    chk("R2", {56'h0, out_byte, core_en}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // directed: all zero, all ones, distinct ramp
    for (int i = 0; i < 20; i++) fb[i] = 8'h00;
    run_frame();
    for (int i = 0; i < 20; i++) fb[i] = 8'hFF;
    run_frame();
    for (int i = 0; i < 20; i++) fb[i] = 8'(i + 1);
    run_frame();
    // back-to-back random frames (R1 wrap)
    for (int f = 0; f < 40; f++) begin
      fill_random();
      run_frame();
    end
    // mid-frame reset (R2)
    for (int c = 0; c < 10; c++) begin
      in_byte = 8'hA5;
      @(negedge clk);
    end
    rst_n = 1'b0;
    @(negedge clk);
    #1;
    chk("R2", {56'h0, out_byte, core_en}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    fill_random();
    run_frame();
    fill_random();
    run_frame();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule